// File: doc/BRIEF.md
# Interrupt Status Register with Clear-on-Read

This block collects eight event lines from a radio receiver into one 8-bit interrupt/status register. It pairs that register with an 8-bit interrupt-enable register. Each event line is edge-detected. For a bit whose enable is set, a rising edge is latched as a pending interrupt. The block drives an active-low, registered interrupt request to the host whenever an enabled flag is pending. When the host reads the status address, it receives the flags as they stood before the read. The same read clears every enabled flag, and the request line is released on the following clock.

A bit whose enable is clear is not stored. It reads as the live level of its event line and a read does not clear it. The exception is the low-battery bit. It latches its event even while masked, keeps it across reads, and raises the request as soon as the host enables it. The host reaches both registers through a simple strobe bus. Each read strobe is answered one clock later with a valid pulse and the data.

Top module: `irq_status_ctrl`

## Requirements
- R1: During synchronous reset `irq_n_o` is high. After reset the enable register reads 8'h00 and `irq_n_o` stays high.
- R2: An enabled flag sets only on a 0-to-1 transition of its event line. A line that stays high after its flag was cleared does not set it again.
- R3: When an enabled flag becomes set on clock edge k, `irq_n_o` goes low on edge k+1. It is still high right after edge k.
- R4: A read of address 7'h04 returns the flags as they were before that read. The read clears every enabled flag, and `irq_n_o` returns high one clock after the clearing edge.
- R5: A bit whose enable is 0 (except low battery) stores nothing. It reads as the current level of its event line, is not cleared by reads, and never pulls `irq_n_o` low. Disabling a pending bit releases `irq_n_o` one clock later.
- R6: The low-battery bit (bit 2) latches a rising edge even while masked. It reads 1 and survives reads while masked. Enabling it later pulls `irq_n_o` low one clock after the enable write takes effect.
- R7: An event edge arriving in the same cycle as a clearing read is not lost. The read returns the old value, the flag stays set afterwards, and `irq_n_o` goes low.
- R8: A write to address 7'h05 loads the enable register (bit i enables flag i). A read of 7'h05 returns the stored value.
- R9: Status bit positions from MSB to LSB: 7 sync word found, 6 valid preamble, 5 invalid preamble, 4 signal strength over threshold, 3 wake-up timer expiry, 2 low battery, 1 crystal ready, 0 power-on reset. Event line `evt_i[i]` feeds status bit i.
- R10: `bus_rvalid_o` is high exactly in the clock after a cycle with `bus_rd_i` high, and is low otherwise.
- R11: The status register is read-only. A write to 7'h04 changes neither the flags nor the enable register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| evt_i | input | 8 | Event lines, one per status bit |
| bus_addr_i | input | 7 | Host register address |
| bus_rd_i | input | 1 | Host read strobe, one cycle per access |
| bus_wr_i | input | 1 | Host write strobe, one cycle per access |
| bus_wdata_i | input | 8 | Host write data |
| bus_rdata_o | output | 8 | Read data, valid with `bus_rvalid_o` |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after the read strobe |
| irq_n_o | output | 1 | Active-low, registered interrupt request |

## Verification
The bench drives an event edge in the same cycle as a clearing read. A design that clears after merging the edge would drop that interrupt and leave the request line high. It checks that the low-battery event is kept while masked and fires after a later enable. A design treating that bit like the others would read 0 or never assert the request. Masked bits are read repeatedly and toggled, so a design that latches or clears them shows a stale 1 or a lost live level. The request line is sampled on both sides of its one-clock latency, so an unregistered or doubly registered request shows up as a timing mismatch.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

   // status bit positions; the host decodes these
   localparam int unsigned FLAG_COUNT  = 8;
   localparam int unsigned POS_SYNC    = 7;
   localparam int unsigned POS_PRE_OK  = 6;
   localparam int unsigned POS_PRE_BAD = 5;
   localparam int unsigned POS_RSSI    = 4;
   localparam int unsigned POS_WAKE    = 3;
   localparam int unsigned POS_LOWBAT  = 2;
   localparam int unsigned POS_XTAL    = 1;
   localparam int unsigned POS_POR     = 0;

   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_STATUS = 2'd1,
      SEL_ENABLE = 2'd2
   } reg_sel_e;

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [WIDTH-1:0] lvl_i,
   output logic [WIDTH-1:0] rise_o
);

   logic [WIDTH-1:0] lvl_q;

   // the previous level is loaded during reset too, so a line already high
   // when reset is released does not count as an edge
   always_ff @(posedge clk_i) begin
      lvl_q <= lvl_i;
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign rise_o[b] = lvl_i[b] & ~lvl_q[b];

      assert_rise_from_low_R2: assert property (@(posedge clk_i) disable iff (rst_i)
         rise_o[b] |-> !$past(lvl_i[b]));
   end

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int unsigned             WIDTH  = 8,
   parameter logic [WIDTH-1:0]        STICKY = WIDTH'(4)
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [WIDTH-1:0] rise_i,
   input  logic [WIDTH-1:0] lvl_i,
   input  logic [WIDTH-1:0] en_i,
   input  logic             clr_i,
   output logic [WIDTH-1:0] flag_o,
   output logic [WIDTH-1:0] view_o
);

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic flag_q;
      logic flag_d;

      if (STICKY[b]) begin : g_sticky
         // stores edges whatever the enable; only an enabled read clears it
         always_comb flag_d = (flag_q & ~(clr_i & en_i[b])) | rise_i[b];
         assign view_o[b] = flag_q;

         assert_lowbat_kept_masked_R6: assert property (@(posedge clk_i) disable iff (rst_i)
            (flag_q && !en_i[b]) |=> flag_q);
      end else begin : g_plain
         // masked: nothing stored, host sees the live line
         always_comb flag_d = en_i[b] ? ((flag_q & ~clr_i) | rise_i[b]) : 1'b0;
         assign view_o[b] = en_i[b] ? flag_q : lvl_i[b];

         assert_masked_not_stored_R5: assert property (@(posedge clk_i) disable iff (rst_i)
            !en_i[b] |=> !flag_q);
      end

      always_ff @(posedge clk_i) begin
         if (rst_i) flag_q <= 1'b0;
         else       flag_q <= flag_d;
      end

      assign flag_o[b] = flag_q;

      // an edge coinciding with a clearing read must survive
      assert_edge_kept_on_clear_R7: assert property (@(posedge clk_i) disable iff (rst_i)
         (rise_i[b] && (en_i[b] || STICKY[b])) |=> flag_q);
   end

endmodule

// File: rtl/irq_host_port.sv
module irq_host_port
   import irq_stat_pkg::*;
#(
   parameter int unsigned              ADDR_W       = 7,
   parameter int unsigned              DATA_W       = 8,
   parameter logic [ADDR_W-1:0]        STATUS_ADDR  = ADDR_W'(4),
   parameter logic [ADDR_W-1:0]        ENABLE_ADDR  = ADDR_W'(5),
   parameter logic [DATA_W-1:0]        ENABLE_RESET = '0
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              rd_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] view_i,
   output logic [DATA_W-1:0] en_o,
   output logic              clr_o,
   output logic              en_wr_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rvalid_o
);

   reg_sel_e          sel;
   logic [DATA_W-1:0] en_q;
   logic [DATA_W-1:0] rdata_q;
   logic              rvalid_q;

   always_comb begin
      if (addr_i == STATUS_ADDR)      sel = SEL_STATUS;
      else if (addr_i == ENABLE_ADDR) sel = SEL_ENABLE;
      else                            sel = SEL_NONE;
   end

   assign clr_o   = rd_i && (sel == SEL_STATUS);
   assign en_wr_o = wr_i && (sel == SEL_ENABLE);

   always_ff @(posedge clk_i) begin
      if (rst_i)        en_q <= ENABLE_RESET;
      else if (en_wr_o) en_q <= wdata_i;
   end

   // status view is captured on the same edge that clears: pre-clear value
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= rd_i;
         if (rd_i) begin
            unique case (sel)
               SEL_STATUS: rdata_q <= view_i;
               SEL_ENABLE: rdata_q <= en_q;
               default:    rdata_q <= '0;
            endcase
         end
      end
   end

   assign en_o     = en_q;
   assign rdata_o  = rdata_q;
   assign rvalid_o = rvalid_q;

   assert_enable_loaded_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      (wr_i && addr_i == ENABLE_ADDR) |=> (en_o == $past(wdata_i)));

   assert_status_write_inert_R11: assert property (@(posedge clk_i) disable iff (rst_i)
      (wr_i && addr_i == STATUS_ADDR) |=> $stable(en_o));

   assert_rvalid_after_rd_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      rd_i |=> rvalid_o);

   assert_rvalid_idle_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      !rd_i |=> !rvalid_o);

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
   parameter int unsigned              NUM_EVT     = irq_stat_pkg::FLAG_COUNT,
   parameter int unsigned              ADDR_W      = 7,
   parameter logic [ADDR_W-1:0]        STATUS_ADDR = ADDR_W'(4),
   parameter logic [ADDR_W-1:0]        ENABLE_ADDR = ADDR_W'(5),
   parameter logic [NUM_EVT-1:0]       STICKY_MASK = NUM_EVT'(1 << irq_stat_pkg::POS_LOWBAT)
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic               bus_rd_i,
   input  logic               bus_wr_i,
   input  logic [NUM_EVT-1:0] bus_wdata_i,
   output logic [NUM_EVT-1:0] bus_rdata_o,
   output logic               bus_rvalid_o,
   output logic               irq_n_o
);

   localparam logic [NUM_EVT-1:0] ENABLE_RESET = '0;

   // elaboration-time parameter checks
   if (NUM_EVT < 1 || NUM_EVT > 32) begin : g_bad_width
      $error("irq_status_ctrl: NUM_EVT must lie in 1..32");
   end
   if (STATUS_ADDR == ENABLE_ADDR) begin : g_bad_addr
      $error("irq_status_ctrl: status and enable addresses collide");
   end
   if (ADDR_W < 1) begin : g_bad_addr_w
      $error("irq_status_ctrl: ADDR_W must be at least 1");
   end

   logic [NUM_EVT-1:0] rise;
   logic [NUM_EVT-1:0] flags;
   logic [NUM_EVT-1:0] view;
   logic [NUM_EVT-1:0] en;
   logic               clr;
   logic               en_wr;
   logic               irq_n_q;

   irq_edge_detect #(
      .WIDTH (NUM_EVT)
   ) i_edge (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .lvl_i  (evt_i),
      .rise_o (rise)
   );

   irq_flag_bank #(
      .WIDTH  (NUM_EVT),
      .STICKY (STICKY_MASK)
   ) i_flags (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .rise_i (rise),
      .lvl_i  (evt_i),
      .en_i   (en),
      .clr_i  (clr),
      .flag_o (flags),
      .view_o (view)
   );

   irq_host_port #(
      .ADDR_W       (ADDR_W),
      .DATA_W       (NUM_EVT),
      .STATUS_ADDR  (STATUS_ADDR),
      .ENABLE_ADDR  (ENABLE_ADDR),
      .ENABLE_RESET (ENABLE_RESET)
   ) i_port (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .addr_i   (bus_addr_i),
      .rd_i     (bus_rd_i),
      .wr_i     (bus_wr_i),
      .wdata_i  (bus_wdata_i),
      .view_i   (view),
      .en_o     (en),
      .clr_o    (clr),
      .en_wr_o  (en_wr),
      .rdata_o  (bus_rdata_o),
      .rvalid_o (bus_rvalid_o)
   );

   // registered request: one clock behind any flag or enable change
   always_ff @(posedge clk_i) begin
      if (rst_i) irq_n_q <= 1'b1;
      else       irq_n_q <= ~|(flags & en);
   end

   assign irq_n_o = irq_n_q;

   assert_irq_high_in_reset_R1: assert property (@(posedge clk_i)
      rst_i |=> irq_n_o);

   assert_irq_after_enabled_edge_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      ((|(rise & en)) && !en_wr) |-> ##2 !irq_n_o);

   assert_irq_released_by_read_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (clr && !(|(rise & en)) && !en_wr) |-> ##2 irq_n_o);

endmodule

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam logic [6:0] A_STATUS = 7'h04;
   localparam logic [6:0] A_ENABLE = 7'h05;

   logic       clk = 1'b0;
   logic       rst_i;
   logic [7:0] evt_i;
   logic [6:0] bus_addr_i;
   logic       bus_rd_i;
   logic       bus_wr_i;
   logic [7:0] bus_wdata_i;
   logic [7:0] bus_rdata_o;
   logic       bus_rvalid_o;
   logic       irq_n_o;

   int n_chk  = 0;
   int n_fail = 0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_status_ctrl i_irq_status_ctrl (
      .clk_i        (clk),
      .rst_i        (rst_i),
      .evt_i        (evt_i),
      .bus_addr_i   (bus_addr_i),
      .bus_rd_i     (bus_rd_i),
      .bus_wr_i     (bus_wr_i),
      .bus_wdata_i  (bus_wdata_i),
      .bus_rdata_o  (bus_rdata_o),
      .bus_rvalid_o (bus_rvalid_o),
      .irq_n_o      (irq_n_o)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk_irq(input string tag, input logic exp);
      chk(tag, {7'b0, irq_n_o}, {7'b0, exp});
   endtask

   // driver: pushes the expected read data, monitor pops it
   task automatic do_read(input logic [6:0] addr, input logic [7:0] exp, input string tag);
      bus_addr_i = addr;
      bus_rd_i   = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      tick();
      bus_rd_i   = 1'b0;
   endtask

   task automatic do_write(input logic [6:0] addr, input logic [7:0] data);
      bus_addr_i  = addr;
      bus_wdata_i = data;
      bus_wr_i    = 1'b1;
      tick();
      bus_wr_i    = 1'b0;
   endtask

   // monitor
   always @(negedge clk) begin
      if (bus_rvalid_o === 1'b1) begin
         if (exp_q.size() == 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10: actual unexpected rvalid expected none");
         end else begin
            chk(tag_q.pop_front(), bus_rdata_o, exp_q.pop_front());
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_i       = 1'b1;
      evt_i       = 8'h00;
      bus_addr_i  = 7'h00;
      bus_rd_i    = 1'b0;
      bus_wr_i    = 1'b0;
      bus_wdata_i = 8'h00;
      repeat (3) tick();
      chk_irq("R1 irq high in reset", 1'b1);
      rst_i = 1'b0;
      tick();
      chk_irq("R1 irq high after reset", 1'b1);
      do_read(A_ENABLE, 8'h00, "R1 enable reset value");

      // enable register write and readback
      do_write(A_ENABLE, 8'hA0);
      chk("R10 no rvalid on write", {7'b0, bus_rvalid_o}, 8'h00);
      do_read(A_ENABLE, 8'hA0, "R8 enable readback");
      tick();
      chk("R10 rvalid single pulse", {7'b0, bus_rvalid_o}, 8'h00);

      // masked bit 4 reads live, never asserts irq
      do_write(A_ENABLE, 8'h80);
      evt_i[4] = 1'b1;
      tick(); tick();
      chk_irq("R5 masked bit no irq", 1'b1);
      do_read(A_STATUS, 8'h10, "R5 masked live high");
      do_read(A_STATUS, 8'h10, "R5 masked not cleared");
      evt_i[4] = 1'b0;
      tick();
      do_read(A_STATUS, 8'h00, "R5 masked follows line low");

      // enabled bit 7: latency and clear-on-read
      evt_i[7] = 1'b1;
      tick();
      chk_irq("R3 irq not yet low", 1'b1);
      tick();
      chk_irq("R3 irq low one clock after flag", 1'b0);
      do_read(A_STATUS, 8'h80, "R4 R9 sync flag bit 7 read");
      chk_irq("R4 irq still low at clearing edge", 1'b0);
      tick();
      chk_irq("R4 irq released after read", 1'b1);
      do_read(A_STATUS, 8'h00, "R2 held level does not re-set");
      tick();
      chk_irq("R2 no irq from held level", 1'b1);
      evt_i[7] = 1'b0;

      // low battery latches while masked
      evt_i[2] = 1'b1;
      tick();
      evt_i[2] = 1'b0;
      tick(); tick();
      chk_irq("R6 masked low battery no irq", 1'b1);
      do_read(A_STATUS, 8'h04, "R6 low battery stored while masked");
      do_read(A_STATUS, 8'h04, "R6 masked low battery survives read");
      do_write(A_ENABLE, 8'h84);
      chk_irq("R6 irq not yet low after enable", 1'b1);
      tick();
      chk_irq("R6 enable raises irq", 1'b0);
      do_read(A_STATUS, 8'h04, "R6 enabled low battery read");
      tick();
      chk_irq("R6 irq released", 1'b1);
      do_read(A_STATUS, 8'h00, "R6 low battery cleared");

      // edge coincident with clearing read
      do_write(A_ENABLE, 8'h01);
      evt_i[0] = 1'b1;
      tick(); tick();
      chk_irq("R3 irq low for bit 0", 1'b0);
      do_read(A_STATUS, 8'h01, "R9 power-on bit 0 read");
      tick();
      chk_irq("R4 irq released bit 0", 1'b1);
      evt_i[0] = 1'b0;
      tick();
      evt_i[0] = 1'b1;
      do_read(A_STATUS, 8'h00, "R7 read returns pre-edge value");
      tick();
      chk_irq("R7 edge kept, irq low", 1'b0);
      do_read(A_STATUS, 8'h01, "R7 flag still set");
      tick();
      chk_irq("R7 irq released", 1'b1);
      evt_i[0] = 1'b0;
      tick();

      // status register is read-only
      do_write(A_STATUS, 8'hFF);
      tick();
      chk_irq("R11 status write no irq", 1'b1);
      do_read(A_ENABLE, 8'h01, "R11 enable unchanged");
      do_read(A_STATUS, 8'h00, "R11 flags unchanged");

      // several bits at once
      do_write(A_ENABLE, 8'hFF);
      evt_i = 8'h8A;
      tick();
      evt_i = 8'h00;
      tick();
      chk_irq("R3 irq low for multi-bit", 1'b0);
      do_read(A_STATUS, 8'h8A, "R9 bits 7 3 1 positions");
      tick();
      chk_irq("R4 irq released multi-bit", 1'b1);
      do_read(A_STATUS, 8'h00, "R4 enabled flags all cleared");

      // disabling a pending bit drops it
      do_write(A_ENABLE, 8'h08);
      evt_i[3] = 1'b1;
      tick();
      evt_i[3] = 1'b0;
      tick();
      chk_irq("R3 wake-up flag irq low", 1'b0);
      do_write(A_ENABLE, 8'h00);
      tick();
      chk_irq("R5 disable releases irq", 1'b1);
      do_read(A_STATUS, 8'h00, "R5 disabled bit shows live low");

      tick(); tick();
      chk("R10 all reads answered", 8'(exp_q.size()), 8'h00);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule